// File: doc/BRIEF.md
# Latched Interrupt Request Controller

This controller collects single-cycle event pulses from a configurable number of sources and turns them into one level-sensitive interrupt request for a processor. Every source has a sticky flag. The flag is set by an event and stays set until software clears it by writing a one to its position. The request line is gated by three things: a per-source enable mask, a global master switch, and an interrupt-disable level that the processor itself drives.

While any of these gates is closed, events keep setting their flags. When the last gate opens, any request that was held back comes out at once, and no new event is needed. Repeated events from a source whose flag is already set merge into that one flag.

Software reaches the state through a simple synchronous register port. A select and a write strobe qualify an address, and read data is combinational. The request output is registered, so it follows its conditions one cycle later.

Top module: `irqc_top`

## Requirements
- R1: After reset, the enable mask, the pending flags and the master switch all read zero, and `irq` is low.
- R2: A high cycle on `src_pulse[i]` sets pending bit i from the next clock edge, and the bit holds until it is cleared.
- R3: A write to offset 1 clears each pending bit whose `bus_wdata` bit is 1. Bits written as 0 keep their value.
- R4: `irq` is high exactly one cycle after a cycle in which some pending bit and its enable bit are both 1, master bit 0 at offset 2 is 1, and `cpu_irq_off` is low. Otherwise it is low one cycle later.
- R5: Events set pending bits while the mask bit, the master switch or `cpu_irq_off` blocks the request.
- R6: A request blocked while pending asserts once every gate opens, with no new event.
- R7: Several events on a source that is already pending leave a single flag, and one clear write removes it.
- R8: When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R9: Register map: offset 0 is the enable mask (bit i enables source i), offset 1 is the pending flags, and offset 2 bit 0 is the master switch with all other bits reading 0. Offset 3 reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | NUM_SRC | Event pulses, one per source, synchronous |
| cpu_irq_off | input | 1 | Processor interrupt-disable level |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Read data for `bus_addr` |
| irq | output | 1 | Registered interrupt request |

## Verification
The two functions that can meet in one cycle are an event on a source and a clearing write to the same flag. The bench raises `src_pulse` in the same cycle as a write of ones to offset 1 on a flag that is already set, then reads the flag back and expects it still set. A second case does the same with a clear write of the flag's own bit. A related overlap is an event that arrives while a gate is closed. This is judged by checking that the flag is latched with `irq` low, and that `irq` rises one cycle after the gate opens.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   // Register offsets within the controller window
   localparam int unsigned OFF_ENABLE  = 0;
   localparam int unsigned OFF_PENDING = 1;
   localparam int unsigned OFF_MASTER  = 2;
   localparam int unsigned MAX_SRC     = 32;
endpackage

// File: rtl/irqc_pending.sv
module irqc_pending #(
   parameter int unsigned NUM_SRC = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] pend_o
);
   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
         logic flag_q;
         always_ff @(posedge clk) begin
            if (!rst_n)         flag_q <= 1'b0;
            else if (src_i[i])  flag_q <= 1'b1;   // event beats clear
            else if (clr_i[i])  flag_q <= 1'b0;
         end
         assign pend_o[i] = flag_q;

         // R2: a set flag with no clear stays set
         a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[i] && !clr_i[i]) |=> pend_o[i]);
         // R8: an event always leaves the flag set, even against a clear
         a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            src_i[i] |=> pend_o[i]);
         // R3: a clear without an event drops the flag
         a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !src_i[i]) |=> !pend_o[i]);
      end
   endgenerate
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned ADDR_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_i,
   input  logic               wr_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [NUM_SRC-1:0] wdata_i,
   input  logic [NUM_SRC-1:0] pend_i,
   output logic [NUM_SRC-1:0] en_o,
   output logic               master_o,
   output logic [NUM_SRC-1:0] clr_o,
   output logic [NUM_SRC-1:0] rdata_o
);
   localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFF_ENABLE);
   localparam logic [ADDR_W-1:0] A_PND = ADDR_W'(OFF_PENDING);
   localparam logic [ADDR_W-1:0] A_MST = ADDR_W'(OFF_MASTER);

   logic               wr_en;
   logic [NUM_SRC-1:0] en_q;
   logic               master_q;

   assign wr_en = sel_i && wr_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= '0;
         master_q <= 1'b0;
      end else if (wr_en) begin
         if (addr_i == A_EN)  en_q     <= wdata_i;
         if (addr_i == A_MST) master_q <= wdata_i[0];
      end
   end

   assign clr_o    = (wr_en && addr_i == A_PND) ? wdata_i : '0;
   assign en_o     = en_q;
   assign master_o = master_q;

   always_comb begin
      rdata_o = '0;
      if (sel_i) begin
         unique case (addr_i)
            A_EN:    rdata_o = en_q;
            A_PND:   rdata_o = pend_i;
            A_MST:   rdata_o[0] = master_q;
            default: rdata_o = '0;
         endcase
      end
   end

   // R9: writes to the enable offset land in the mask
   a_r9_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr_i == A_EN) |=> (en_o == $past(wdata_i)));
endmodule

// File: rtl/irqc_gate.sv
module irqc_gate #(
   parameter int unsigned NUM_SRC = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend_i,
   input  logic [NUM_SRC-1:0] en_i,
   input  logic               master_i,
   input  logic               cpu_off_i,
   output logic               irq_o
);
   logic any_live;
   assign any_live = |(pend_i & en_i);

   always_ff @(posedge clk) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= any_live && master_i && !cpu_off_i;
   end

   // R4: a fully open gate with a live source raises the line next cycle
   a_r4_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (any_live && master_i && !cpu_off_i) |=> irq_o);
   // R4: any closed gate drops the line next cycle
   a_r4_block: assert property (@(posedge clk) disable iff (!rst_n)
      (!master_i || cpu_off_i) |=> !irq_o);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_SRC = 16,
   parameter int unsigned ADDR_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_pulse,
   input  logic               cpu_irq_off,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [NUM_SRC-1:0] bus_wdata,
   output logic [NUM_SRC-1:0] bus_rdata,
   output logic               irq
);
   generate
      if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_src
         $error("irqc_top: NUM_SRC out of range");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("irqc_top: ADDR_W must cover three offsets");
      end
   endgenerate

   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] en;
   logic [NUM_SRC-1:0] clr;
   logic               master;

   irqc_pending #(.NUM_SRC(NUM_SRC)) u_pend (
      .clk(clk), .rst_n(rst_n), .src_i(src_pulse), .clr_i(clr), .pend_o(pend)
   );

   irqc_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel_i(bus_sel), .wr_i(bus_wr),
      .addr_i(bus_addr), .wdata_i(bus_wdata), .pend_i(pend),
      .en_o(en), .master_o(master), .clr_o(clr), .rdata_o(bus_rdata)
   );

   irqc_gate #(.NUM_SRC(NUM_SRC)) u_gate (
      .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en),
      .master_i(master), .cpu_off_i(cpu_irq_off), .irq_o(irq)
   );

   // R1: nothing requests during or straight after reset
   a_r1_quiet: assert property (@(posedge clk) !rst_n |=> !irq);
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
   localparam int N = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] src_pulse = '0;
   logic         cpu_irq_off = 1'b0;
   logic         bus_sel = 1'b0;
   logic         bus_wr = 1'b0;
   logic [1:0]   bus_addr = '0;
   logic [N-1:0] bus_wdata = '0;
   logic [N-1:0] bus_rdata;
   logic         irq;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   irqc_top #(.NUM_SRC(N), .ADDR_W(2)) dut (
      .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .cpu_irq_off(cpu_irq_off),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // vector: src[53:38] wr[37] addr[36:35] wdata[34:19] off[18] exp_pend[17:2] exp_irq[1] pad[0]
   localparam int NV = 13;
   localparam logic [53:0] TBL [NV] = '{
      {16'h0001, 1'b0, 2'd0, 16'h0000, 1'b0, 16'h0001, 1'b0, 1'b0}, // R5 latched while gated
      {16'h0000, 1'b1, 2'd0, 16'h0003, 1'b0, 16'h0001, 1'b0, 1'b0}, // R5 master still off
      {16'h0000, 1'b1, 2'd2, 16'h0001, 1'b0, 16'h0001, 1'b1, 1'b0}, // R6 held request fires
      {16'h0000, 1'b0, 2'd0, 16'h0000, 1'b1, 16'h0001, 1'b0, 1'b0}, // R4 cpu disable
      {16'h0002, 1'b0, 2'd0, 16'h0000, 1'b0, 16'h0003, 1'b1, 1'b0}, // R2 second source
      {16'h0000, 1'b1, 2'd1, 16'h0001, 1'b0, 16'h0002, 1'b1, 1'b0}, // R3 clear one bit
      {16'h0000, 1'b1, 2'd0, 16'h0001, 1'b0, 16'h0002, 1'b0, 1'b0}, // R4 masked
      {16'h0002, 1'b0, 2'd0, 16'h0000, 1'b0, 16'h0002, 1'b0, 1'b0}, // R7 repeat event
      {16'h0000, 1'b1, 2'd1, 16'h0000, 1'b0, 16'h0002, 1'b0, 1'b0}, // R3 zero write
      {16'h0000, 1'b1, 2'd1, 16'h0002, 1'b0, 16'h0000, 1'b0, 1'b0}, // R7 one clear
      {16'h8000, 1'b0, 2'd0, 16'h0000, 1'b0, 16'h8000, 1'b0, 1'b0}, // R2 top source
      {16'h0000, 1'b1, 2'd0, 16'h8000, 1'b0, 16'h8000, 1'b1, 1'b0}, // R6 mask opened
      {16'h0000, 1'b1, 2'd2, 16'h0000, 1'b0, 16'h8000, 1'b0, 1'b0}  // R4 master off
   };

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   initial begin : main
      logic [N-1:0] d;
      repeat (3) tick();
      check("R1 irq", {15'd0, irq}, '0);
      rd(2'd0, d); check("R1 enable", d, '0);
      rd(2'd1, d); check("R1 pending", d, '0);
      rd(2'd2, d); check("R1 master", d, '0);
      rst_n = 1'b1;
      tick();

      for (int v = 0; v < NV; v++) begin
         src_pulse   = TBL[v][53:38];
         bus_sel     = TBL[v][37];
         bus_wr      = TBL[v][37];
         bus_addr    = TBL[v][36:35];
         bus_wdata   = TBL[v][34:19];
         cpu_irq_off = TBL[v][18];
         tick();
         src_pulse = '0; bus_wr = 1'b0; bus_wdata = '0;
         tick();
         rd(2'd1, d);
         check($sformatf("R2/R3 vector %0d pending", v), d, TBL[v][17:2]);
         check($sformatf("R4 vector %0d irq", v), {15'd0, irq}, {15'd0, TBL[v][1]});
         bus_sel = 1'b0;
      end

      // R8: event and clear on the same pending bit in one cycle
      src_pulse = 16'h8000;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 16'hFFFF;
      tick();
      src_pulse = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
      rd(2'd1, d); check("R8 event beats clear", d, 16'h8000);
      // R8 with a clear of the flag's own bit only
      src_pulse = 16'h0010;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 16'h0010;
      tick();
      src_pulse = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
      rd(2'd1, d); check("R8 own-bit clear loses", d, 16'h8010);

      // R9: map and unused offset
      wr(2'd3, 16'hFFFF);
      rd(2'd3, d); check("R9 offset 3 reads zero", d, '0);
      rd(2'd0, d); check("R9 enable unchanged", d, 16'h8000);
      rd(2'd2, d); check("R9 master unchanged", d, '0);
      wr(2'd2, 16'hFFFF);
      rd(2'd2, d); check("R9 master only bit 0", d, 16'h0001);

      // R4 latency: line rises exactly one cycle after the conditions hold
      wr(2'd1, 16'hFFFF);
      wr(2'd0, 16'h0001);
      tick();
      check("R4 idle low", {15'd0, irq}, '0);
      src_pulse = 16'h0001;
      tick();
      src_pulse = '0;
      check("R4 not yet", {15'd0, irq}, '0);
      tick();
      check("R4 one cycle later", {15'd0, irq}, 16'h0001);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule